// File: doc/BRIEF.md
# Skip-Column Clock Compensation Buffer

This block is a dual-clock elastic buffer on the receive path of a four-lane serial link. Each column is four lanes of code-groups, written as one byte plus one control flag per lane. Columns arrive on the recovered receive clock and leave on the fabric clock. The two clocks have the same nominal rate but may drift or jitter against each other. The block absorbs that difference by dropping or repeating whole skip columns. It never drops or repeats a data column, and it never splits a column across lanes.

The write side keeps the buffer from filling. When its view of the fill level is high and a skip column arrives, that column is not stored. The read side keeps the buffer from draining. When its view of the fill level is low and the column it has just presented is a skip column, it presents that column once more and holds its read pointer.

Each side posts a one-cycle pulse in its own clock domain whenever it compensates. Pointers cross between the domains in Gray code. If a side runs past the end of the buffer, it sets a sticky error flag and moves its own pointer so that the buffer sits at nominal fill.

Top module: `skip_elastic_buf`

## Requirements
- R1: While either reset is low, and right after both are released, the read side presents a skip column. The insert and delete pulses and both error flags are 0.
- R2: When no overflow or underflow occurs, non-skip columns leave on the read side in the order they were written. None is lost and none is repeated.
- R3: When the write side's fill view is at or above HI_MARK (default 12) and the column on the write inputs is a skip column, that column is not stored. `del_evt` is high for the one write cycle after the edge that sampled it.
- R4: A skip column has all four lanes equal to 0x1C with every control flag set (`wr_data` = 0x1C1C1C1C, `wr_k` = 4'hF). Only such a column is ever deleted.
- R5: When the read side's fill view is at or below LO_MARK (default 4) and the column currently presented is a skip column that was not itself inserted, the next read cycle presents the same column again with `ins_evt` high, and the read pointer does not advance.
- R6: `ins_evt` is never high in two consecutive read cycles.
- R7: When the write side's fill view equals DEPTH and a non-skip column must be stored, the column is dropped, `ovf_err` is set, and the write pointer is moved to NOMINAL columns ahead of the synchronized read pointer.
- R8: When the read side's fill view is 0 and no insertion is due, `unf_err` is set, a skip column is presented, and the read pointer is moved to NOMINAL columns behind the synchronized write pointer.
- R9: `ovf_err` and `unf_err` stay set until their domain's reset, regardless of later traffic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Recovered receive clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write domain |
| wr_data | input | 32 | Incoming column; lane n in bits 8n+7:8n |
| wr_k | input | 4 | Control flag per incoming lane |
| del_evt | output | 1 | Pulse: a skip column was deleted (write domain) |
| ovf_err | output | 1 | Sticky overflow flag (write domain) |
| rd_clk | input | 1 | Fabric clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read domain |
| rd_data | output | 32 | Outgoing column, same lane layout |
| rd_k | output | 4 | Control flag per outgoing lane |
| ins_evt | output | 1 | Pulse: the presented skip column is a repeat (read domain) |
| unf_err | output | 1 | Sticky underflow flag (read domain) |

## Verification
Some properties are checked by assertions on every edge of their own domain:
- a deletion happens only on a skip column and only at high fill;
- an insertion repeats the previous skip column, happens only at low fill, and never happens twice in a row;
- an error flag rises only when its side's fill view is at its limit, and once set it stays set.

Other behaviour only the bench scenarios can show, by running the two clocks at equal, faster and slower ratios:
- the end-to-end order of data columns;
- that compensation actually takes place when the rates differ;
- that overflow and underflow are reached when no skip columns are available.

// File: rtl/seb_pkg.sv
package seb_pkg;
    localparam int NUM_LANES = 4;
    localparam int LANE_W    = 8;
    localparam int COL_DW    = NUM_LANES * LANE_W;
    localparam logic [LANE_W-1:0] SKIP_CODE = 8'h1C;

    typedef struct packed {
        logic [NUM_LANES-1:0] k;
        logic [COL_DW-1:0]    d;
    } column_t;

    function automatic column_t skip_column();
        column_t c;
        c.k = '1;
        c.d = {NUM_LANES{SKIP_CODE}};
        return c;
    endfunction

    function automatic logic is_skip(column_t c);
        return c == skip_column();
    endfunction
endpackage

// File: rtl/seb_gray_sync.sv
module seb_gray_sync #(
    parameter int             W       = 5,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/seb_col_store.sv
module seb_col_store
    import seb_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  column_t       wcol,
    input  logic [AW-1:0] raddr,
    output column_t       rcol
);
    column_t mem_q [DEPTH];

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= skip_column();
        end else if (we) begin
            mem_q[waddr] <= wcol;
        end
    end

    assign rcol = mem_q[raddr];
endmodule

// File: rtl/seb_wr_ctrl.sv
module seb_wr_ctrl
    import seb_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int HI_MARK = 12,
    parameter int NOMINAL = 8,
    localparam int AW     = $clog2(DEPTH),
    localparam int PW     = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  column_t       in_col,
    input  logic [PW-1:0] rgray_sync,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic [PW-1:0] fill,
    output logic          del_evt,
    output logic          ovf_err
);
    localparam logic [PW-1:0] NOM_P   = PW'(NOMINAL);
    localparam logic [PW-1:0] NOM_G   = NOM_P ^ (NOM_P >> 1);
    localparam logic [PW-1:0] HI_P    = PW'(HI_MARK);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] wgray;
        logic          del;
        logic          ovf;
    } wst_t;

    wst_t st_q, st_d;
    logic [PW-1:0] rbin;
    logic          we_d;

    function automatic logic [PW-1:0] g2b(logic [PW-1:0] g);
        logic [PW-1:0] b;
        for (int i = 0; i < PW; i++) b[i] = ^(g >> i);
        return b;
    endfunction

    always_comb begin
        rbin     = g2b(rgray_sync);
        fill     = st_q.wptr - rbin;
        st_d     = st_q;
        st_d.del = 1'b0;
        we_d     = 1'b0;
        if (is_skip(in_col) && fill >= HI_P) begin
            st_d.del = 1'b1;
        end else if (fill >= DEPTH_P) begin
            st_d.ovf  = 1'b1;
            st_d.wptr = rbin + NOM_P;
        end else begin
            we_d      = 1'b1;
            st_d.wptr = st_q.wptr + 1'b1;
        end
        st_d.wgray = st_d.wptr ^ (st_d.wptr >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{wptr: NOM_P, wgray: NOM_G, del: 1'b0, ovf: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign we      = we_d;
    assign waddr   = st_q.wptr[AW-1:0];
    assign wgray   = st_q.wgray;
    assign del_evt = st_q.del;
    assign ovf_err = st_q.ovf;
endmodule

// File: rtl/seb_rd_ctrl.sv
module seb_rd_ctrl
    import seb_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int LO_MARK = 4,
    parameter int NOMINAL = 8,
    localparam int AW     = $clog2(DEPTH),
    localparam int PW     = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] wgray_sync,
    input  column_t       mem_col,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output logic [PW-1:0] fill,
    output column_t       out_col,
    output logic          ins_evt,
    output logic          unf_err
);
    localparam logic [PW-1:0] NOM_P = PW'(NOMINAL);
    localparam logic [PW-1:0] LO_P  = PW'(LO_MARK);

    typedef struct packed {
        logic [PW-1:0] rptr;
        logic [PW-1:0] rgray;
        column_t       col;
        logic          ins;
        logic          unf;
    } rst_t;

    rst_t st_q, st_d;
    logic [PW-1:0] wbin;

    function automatic logic [PW-1:0] g2b(logic [PW-1:0] g);
        logic [PW-1:0] b;
        for (int i = 0; i < PW; i++) b[i] = ^(g >> i);
        return b;
    endfunction

    always_comb begin
        wbin     = g2b(wgray_sync);
        fill     = wbin - st_q.rptr;
        st_d     = st_q;
        st_d.ins = 1'b0;
        if (is_skip(st_q.col) && !st_q.ins && fill <= LO_P) begin
            st_d.ins = 1'b1;
        end else if (fill == '0) begin
            st_d.unf  = 1'b1;
            st_d.col  = skip_column();
            st_d.rptr = wbin - NOM_P;
        end else begin
            st_d.col  = mem_col;
            st_d.rptr = st_q.rptr + 1'b1;
        end
        st_d.rgray = st_d.rptr ^ (st_d.rptr >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{rptr: '0, rgray: '0, col: skip_column(), ins: 1'b0, unf: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign raddr   = st_q.rptr[AW-1:0];
    assign rgray   = st_q.rgray;
    assign out_col = st_q.col;
    assign ins_evt = st_q.ins;
    assign unf_err = st_q.unf;
endmodule

// File: rtl/skip_elastic_buf.sv
module skip_elastic_buf
    import seb_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int HI_MARK = 12,
    parameter int LO_MARK = 4,
    parameter int NOMINAL = 8,
    parameter int STAGES  = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic [COL_DW-1:0] wr_data,
    input  logic [NUM_LANES-1:0] wr_k,
    output logic              del_evt,
    output logic              ovf_err,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    output logic [COL_DW-1:0] rd_data,
    output logic [NUM_LANES-1:0] rd_k,
    output logic              ins_evt,
    output logic              unf_err
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] NOM_P = PW'(NOMINAL);
    localparam logic [PW-1:0] NOM_G = NOM_P ^ (NOM_P >> 1);

    column_t       in_col, mem_col, out_col;
    logic          we;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
    logic [PW-1:0] wr_fill, rd_fill;

    assign in_col = '{k: wr_k, d: wr_data};

    seb_col_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .we(we), .waddr(waddr),
        .wcol(in_col), .raddr(raddr), .rcol(mem_col)
    );

    seb_wr_ctrl #(.DEPTH(DEPTH), .HI_MARK(HI_MARK), .NOMINAL(NOMINAL)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .in_col(in_col), .rgray_sync(rgray_s),
        .we(we), .waddr(waddr), .wgray(wgray), .fill(wr_fill),
        .del_evt(del_evt), .ovf_err(ovf_err)
    );

    seb_gray_sync #(.W(PW), .STAGES(STAGES), .RST_VAL('0)) u_r2w (
        .clk(wr_clk), .rst_n(wr_rst_n), .din(rgray), .dout(rgray_s)
    );

    seb_gray_sync #(.W(PW), .STAGES(STAGES), .RST_VAL(NOM_G)) u_w2r (
        .clk(rd_clk), .rst_n(rd_rst_n), .din(wgray), .dout(wgray_s)
    );

    seb_rd_ctrl #(.DEPTH(DEPTH), .LO_MARK(LO_MARK), .NOMINAL(NOMINAL)) u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .wgray_sync(wgray_s), .mem_col(mem_col),
        .raddr(raddr), .rgray(rgray), .fill(rd_fill), .out_col(out_col),
        .ins_evt(ins_evt), .unf_err(unf_err)
    );

    assign rd_data = out_col.d;
    assign rd_k    = out_col.k;
endmodule

// File: rtl/seb_checker.sv
module seb_checker
    import seb_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int HI_MARK = 12,
    parameter int LO_MARK = 4,
    parameter int PW      = 5
) (
    input logic                 wr_clk,
    input logic                 wr_rst_n,
    input logic                 rd_clk,
    input logic                 rd_rst_n,
    input logic [COL_DW-1:0]    wr_data,
    input logic [NUM_LANES-1:0] wr_k,
    input logic                 del_evt,
    input logic                 ovf_err,
    input logic [COL_DW-1:0]    rd_data,
    input logic [NUM_LANES-1:0] rd_k,
    input logic                 ins_evt,
    input logic                 unf_err,
    input logic [PW-1:0]        wr_fill,
    input logic [PW-1:0]        rd_fill
);
    localparam logic [COL_DW-1:0] SKIP_D = {NUM_LANES{SKIP_CODE}};

    a_r3_del_at_high_fill: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        del_evt |-> ($past(wr_fill) >= PW'(HI_MARK)));

    a_r4_del_only_skip: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        del_evt |-> ($past(wr_k) == '1 && $past(wr_data) == SKIP_D));

    a_r5_ins_repeats_skip: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        ins_evt |-> (rd_k == '1 && rd_data == SKIP_D && $stable(rd_data) && $stable(rd_k)));

    a_r5_ins_at_low_fill: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        ins_evt |-> ($past(rd_fill) <= PW'(LO_MARK)));

    a_r6_no_double_insert: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        ins_evt |=> !ins_evt);

    a_r7_ovf_when_full: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $rose(ovf_err) |-> ($past(wr_fill) >= PW'(DEPTH)));

    a_r8_unf_when_empty: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $rose(unf_err) |-> ($past(rd_fill) == '0 && rd_k == '1));

    a_r9_ovf_sticky: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        ovf_err |=> ovf_err);

    a_r9_unf_sticky: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        unf_err |=> unf_err);
endmodule

bind skip_elastic_buf seb_checker #(
    .DEPTH(DEPTH), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK), .PW(PW)
) u_chk (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .wr_data(wr_data), .wr_k(wr_k), .del_evt(del_evt), .ovf_err(ovf_err),
    .rd_data(rd_data), .rd_k(rd_k), .ins_evt(ins_evt), .unf_err(unf_err),
    .wr_fill(wr_fill), .rd_fill(rd_fill)
);

// File: tb/tb_skip_elastic_buf.sv
`timescale 1ns/1ps
module tb_skip_elastic_buf;
    localparam logic [31:0] SKIP_D = 32'h1C1C1C1C;
    localparam logic [3:0]  SKIP_K = 4'hF;

    typedef struct packed {
        int   half_ps;
        int   skip_every;
        int   ncols;
        logic want_del;
        logic want_ins;
        logic exp_ovf;
        logic exp_unf;
    } row_t;

    localparam int NROWS = 5;
    localparam row_t ROWS [NROWS] = '{
        '{4000, 8, 400, 1'b0, 1'b0, 1'b0, 1'b0},
        '{3500, 4, 600, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4500, 4, 600, 1'b0, 1'b1, 1'b0, 1'b0},
        '{3500, 0, 400, 1'b0, 1'b0, 1'b1, 1'b0},
        '{4500, 0, 400, 1'b0, 1'b0, 1'b0, 1'b1}
    };

    logic wr_clk = 1'b0, rd_clk = 1'b0;
    logic wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic [31:0] wr_data = SKIP_D;
    logic [3:0]  wr_k = SKIP_K;
    logic del_evt, ovf_err, ins_evt, unf_err;
    logic [31:0] rd_data;
    logic [3:0]  rd_k;

    real wr_half = 4.0;
    always #(wr_half) wr_clk = ~wr_clk;
    always #4 rd_clk = ~rd_clk;

    skip_elastic_buf dut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_data(wr_data), .wr_k(wr_k),
        .del_evt(del_evt), .ovf_err(ovf_err),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_data(rd_data), .rd_k(rd_k),
        .ins_evt(ins_evt), .unf_err(unf_err)
    );

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    // read-side scoreboard state
    bit   sb_en = 1'b0;
    int   exp_tag, mism, first_act, first_exp, rx_cnt, ins_cnt, ins_bad, ins_dbl;
    logic [35:0] prev_col;
    logic prev_ins;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(negedge rd_clk) begin
        if (sb_en) begin
            if (rd_k == SKIP_K && rd_data == SKIP_D) begin
                if (ins_evt) begin
                    ins_cnt++;
                    if (prev_col != {rd_k, rd_data}) ins_bad++;
                    if (prev_ins) ins_dbl++;
                end
            end else begin
                if (ins_evt) ins_bad++;
                if (rd_k != 4'h0 || rd_data != 32'(exp_tag)) begin
                    if (mism == 0) begin first_act = int'(rd_data); first_exp = exp_tag; end
                    mism++;
                end
                exp_tag = int'(rd_data) + 1;
                rx_cnt++;
            end
            prev_col = {rd_k, rd_data};
            prev_ins = ins_evt;
        end
    end

    task automatic do_reset();
        wr_data = SKIP_D; wr_k = SKIP_K;
        wr_rst_n = 1'b0; rd_rst_n = 1'b0;
        #40;
        @(negedge wr_clk) wr_rst_n = 1'b1;
        @(negedge rd_clk) rd_rst_n = 1'b1;
    endtask

    int del_cnt, del_bad, n_data;

    task automatic drive_row(input row_t r, input bit rst_first);
        bit last_skip;
        int tag;
        wr_half = real'(r.half_ps) / 1000.0;
        if (rst_first) do_reset();
        exp_tag = 0; mism = 0; rx_cnt = 0; ins_cnt = 0; ins_bad = 0; ins_dbl = 0;
        prev_col = {SKIP_K, SKIP_D}; prev_ins = 1'b0;
        del_cnt = 0; del_bad = 0; n_data = 0; tag = 0; last_skip = 1'b1;
        sb_en = 1'b1;
        for (int c = 0; c < r.ncols; c++) begin
            @(negedge wr_clk);
            if (del_evt) begin del_cnt++; if (!last_skip) del_bad++; end
            if (r.skip_every != 0 && (c % r.skip_every) == r.skip_every - 1) begin
                wr_data = SKIP_D; wr_k = SKIP_K; last_skip = 1'b1;
            end else begin
                wr_data = 32'(tag); wr_k = 4'h0; tag++; n_data++; last_skip = 1'b0;
            end
        end
        @(negedge wr_clk);
        if (del_evt) begin del_cnt++; if (!last_skip) del_bad++; end
        wr_data = SKIP_D; wr_k = SKIP_K;
        repeat (30) @(negedge rd_clk);
        sb_en = 1'b0;
    endtask

    initial begin
        // table of rate scenarios
        for (int i = 0; i < NROWS; i++) begin
            drive_row(ROWS[i], 1'b1);
            if (!ROWS[i].exp_ovf && !ROWS[i].exp_unf) begin
                check(mism == 0, "R2", $sformatf("row%0d data order", i), first_act, first_exp);
                check(rx_cnt >= n_data - 24 && rx_cnt <= n_data, "R2",
                      $sformatf("row%0d data count", i), rx_cnt, n_data);
            end
            check(del_bad == 0, "R4", $sformatf("row%0d deletions of non-skip", i), del_bad, 0);
            check(ins_bad == 0, "R5", $sformatf("row%0d bad insertions", i), ins_bad, 0);
            check(ins_dbl == 0, "R6", $sformatf("row%0d back-to-back insertions", i), ins_dbl, 0);
            if (ROWS[i].want_del)
                check(del_cnt > 0, "R3", $sformatf("row%0d deletion count", i), del_cnt, 1);
            if (ROWS[i].want_ins)
                check(ins_cnt > 0, "R5", $sformatf("row%0d insertion count", i), ins_cnt, 1);
            check(ovf_err == ROWS[i].exp_ovf, "R7", $sformatf("row%0d overflow flag", i),
                  ovf_err, ROWS[i].exp_ovf);
            check(unf_err == ROWS[i].exp_unf, "R8", $sformatf("row%0d underflow flag", i),
                  unf_err, ROWS[i].exp_unf);
        end

        // directed: reset state
        do_reset();
        @(negedge rd_clk);
        check(rd_data == SKIP_D, "R1", "reset rd_data", rd_data, SKIP_D);
        check(rd_k == SKIP_K, "R1", "reset rd_k", rd_k, SKIP_K);
        check(ins_evt == 1'b0 && del_evt == 1'b0, "R1", "reset pulses", {ins_evt, del_evt}, 0);
        check(ovf_err == 1'b0 && unf_err == 1'b0, "R1", "reset error flags", {ovf_err, unf_err}, 0);

        // directed: overflow stays set under balanced skip traffic, clears on reset
        drive_row('{3500, 0, 400, 1'b0, 1'b0, 1'b1, 1'b0}, 1'b1);
        check(ovf_err == 1'b1, "R7", "overflow raised", ovf_err, 1);
        drive_row('{4000, 1, 200, 1'b0, 1'b0, 1'b1, 1'b0}, 1'b0);
        check(ovf_err == 1'b1, "R9", "overflow sticky", ovf_err, 1);
        do_reset();
        @(negedge wr_clk);
        check(ovf_err == 1'b0, "R9", "overflow cleared by reset", ovf_err, 0);

        // directed: underflow stays set, clears on reset
        drive_row('{4500, 0, 400, 1'b0, 1'b0, 1'b0, 1'b1}, 1'b1);
        check(unf_err == 1'b1, "R8", "underflow raised", unf_err, 1);
        drive_row('{4000, 1, 200, 1'b0, 1'b0, 1'b0, 1'b1}, 1'b0);
        check(unf_err == 1'b1, "R9", "underflow sticky", unf_err, 1);
        do_reset();
        @(negedge rd_clk);
        check(unf_err == 1'b0, "R9", "underflow cleared by reset", unf_err, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule